// File: doc/BRIEF.md
# Grouped Interrupt Status Controller

This block gathers single-cycle event pulses from a DMA engine into sticky status bits, and it tracks two level causes from a MAC core. Each event belongs either to a normal group or to an abnormal group. Each group has a summary bit that is set while any status bit of that group is set and enabled. The two MAC level causes count in the normal group. One registered interrupt line goes to the processor. It is high while a group summary is set and that group's own enable is set.

Software uses a plain read/write register port with two addresses. Address 0 holds the status word, and software clears event bits there by writing 1. Address 1 holds the enable word, which has one enable per event, one per MAC cause and one per group. Events are not queued. A bit that is already set absorbs any repeats. Several events in one cycle give a single interrupt assertion. The interrupt can rise again only after software has cleared the causes and a new event arrives.

With the default parameters the status word has this layout:
- normal events at bits 7:0, with the receive-complete event at bit 6
- abnormal events at bits 15:8
- the normal summary at bit 16 and the abnormal summary at bit 17
- the time-stamp-trigger cause at bit 20 and the power-management cause at bit 21

Top module: `irq_status_ctrl`

## Requirements
- R1: An event pulse on input bit i sets status bit i at the clock edge where the pulse is sampled. Normal events use bits N_NORM-1:0, so 7:0 by default, and bit 6 is receive-complete. Abnormal events use the next N_ABN bits, so 15:8 by default.
- R2: A write to address 0 clears each event status bit whose data bit is 1. Event status bits whose data bit is 0 keep their value.
- R3: When an event pulse and a write-1 clear of the same bit fall in the same cycle, the bit stays set.
- R4: Events are not queued. A repeated event on a bit that is already set leaves the status word unchanged, and the interrupt stays high with no drop.
- R5: Status bit 16 is the OR of (status AND enable) over the normal events and the two MAC causes. Status bit 17 is the same OR over the abnormal events. A set status bit whose enable is 0 stays visible in the status word but does not set its summary. A summary falls once every enabled bit of its group has been cleared.
- R6: The irq output is registered. It equals (summary16 AND enable bit 16) OR (summary17 AND enable bit 17) from the previous cycle, so it moves one edge after the status word.
- R7: Status bits 20 and 21 follow the time-stamp and power-management level inputs with one cycle of delay. Software writes cannot clear these bits.
- R8: Address 1 is the enable word, and only bits 15:0, 17:16 and 21:20 are stored in it. All other bits read 0. The summary bits cannot be written, and reads at any other address return 0.
- R9: After reset the status word, the enable word and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| norm_evt | input | N_NORM | Normal-group event pulses |
| abn_evt | input | N_ABN | Abnormal-group event pulses |
| mac_ts_lvl | input | 1 | MAC time-stamp-trigger cause, level |
| mac_pm_lvl | input | 1 | MAC power-management cause, level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0 status, 1 enable) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address, combinational read |
| rd_data | output | DATA_W | Read data |
| irq | output | 1 | Registered interrupt request |

## Verification
A status flop that is stuck or lost shows up in the status word at the first read after the edge that should have moved it. The irq line shows the same fault one edge later. An enable or summary that is decoded wrongly can leave a masked bit still raising irq, or leave an unmasked one silent. Such a fault appears at irq on the second edge after the event, so the checks read the status word one edge after each stimulus and read irq one edge after that. The same-cycle clear against event race, the clear attempts on MAC bits and the group-enable gating are each exercised so that the affected bit becomes visible before the next stimulus.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

   // fixed bit positions in the status / enable words
   localparam int SUM_N_BIT   = 16;
   localparam int SUM_A_BIT   = 17;
   localparam int MAC_TS_BIT  = 20;
   localparam int MAC_PM_BIT  = 21;
   localparam int RX_DONE_BIT = 6;

   // register addresses
   localparam int STAT_ADDR = 0;
   localparam int EN_ADDR   = 1;

   typedef struct packed {
      logic pm;
      logic ts;
   } mac_lvl_t;

endpackage

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] clr,
   output logic [W-1:0] stat
);

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= 1'b0;
            else if (evt[i]) q <= 1'b1;   // event has priority over clear
            else if (clr[i]) q <= 1'b0;
         end
         assign stat[i] = q;
      end
   endgenerate

endmodule

// File: rtl/irq_grp_sum.sv
module irq_grp_sum #(
   parameter int W = 8
) (
   input  logic [W-1:0] stat,
   input  logic [W-1:0] en,
   output logic         any
);

   assign any = |(stat & en);

endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic sum_n,
   input  logic sum_a,
   input  logic gen_n,
   input  logic gen_a,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= (sum_n & gen_n) | (sum_a & gen_a);
   end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
   import irq_stat_pkg::*;
#(
   parameter int N_NORM = 8,
   parameter int N_ABN  = 8,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_NORM-1:0] norm_evt,
   input  logic [N_ABN-1:0]  abn_evt,
   input  logic              mac_ts_lvl,
   input  logic              mac_pm_lvl,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);

   localparam int N_EV = N_NORM + N_ABN;

   // elaboration-time parameter checks
   generate
      if (N_NORM <= RX_DONE_BIT) begin : g_chk_norm
         $error("N_NORM must cover the receive-complete bit");
      end
      if (N_ABN < 1) begin : g_chk_abn
         $error("N_ABN must be at least 1");
      end
      if (N_EV > SUM_N_BIT) begin : g_chk_ev
         $error("event bits overlap the summary bits");
      end
      if (DATA_W <= MAC_PM_BIT) begin : g_chk_dw
         $error("DATA_W too narrow for the status layout");
      end
      if (ADDR_W < 1) begin : g_chk_aw
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   logic [N_EV-1:0] ev_q, ev_en_q, ev_clr;
   logic            grp_n_en_q, grp_a_en_q;
   mac_lvl_t        mac_q, mac_en_q;
   logic            sum_n, sum_a;
   logic            wr_stat, wr_en_reg;
   logic [DATA_W-1:0] stat_word, en_word;
   logic            unused_wr;

   assign wr_stat   = wr_en && (wr_addr == ADDR_W'(STAT_ADDR));
   assign wr_en_reg = wr_en && (wr_addr == ADDR_W'(EN_ADDR));
   assign ev_clr    = wr_stat ? wr_data[N_EV-1:0] : '0;
   assign unused_wr = ^wr_data;

   irq_evt_bank #(.W(N_EV)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   ({abn_evt, norm_evt}),
      .clr   (ev_clr),
      .stat  (ev_q)
   );

   // enable word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_en_q    <= '0;
         grp_n_en_q <= 1'b0;
         grp_a_en_q <= 1'b0;
         mac_en_q   <= '0;
      end else if (wr_en_reg) begin
         ev_en_q     <= wr_data[N_EV-1:0];
         grp_n_en_q  <= wr_data[SUM_N_BIT];
         grp_a_en_q  <= wr_data[SUM_A_BIT];
         mac_en_q.ts <= wr_data[MAC_TS_BIT];
         mac_en_q.pm <= wr_data[MAC_PM_BIT];
      end
   end

   // MAC causes are level-following, never software-cleared
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mac_q <= '0;
      else begin
         mac_q.ts <= mac_ts_lvl;
         mac_q.pm <= mac_pm_lvl;
      end
   end

   irq_grp_sum #(.W(N_NORM + 2)) u_sum_n (
      .stat ({mac_q.pm, mac_q.ts, ev_q[N_NORM-1:0]}),
      .en   ({mac_en_q.pm, mac_en_q.ts, ev_en_q[N_NORM-1:0]}),
      .any  (sum_n)
   );

   irq_grp_sum #(.W(N_ABN)) u_sum_a (
      .stat (ev_q[N_EV-1:N_NORM]),
      .en   (ev_en_q[N_EV-1:N_NORM]),
      .any  (sum_a)
   );

   irq_out_reg u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .sum_n (sum_n),
      .sum_a (sum_a),
      .gen_n (grp_n_en_q),
      .gen_a (grp_a_en_q),
      .irq   (irq)
   );

   always_comb begin
      stat_word             = '0;
      stat_word[N_EV-1:0]   = ev_q;
      stat_word[SUM_N_BIT]  = sum_n;
      stat_word[SUM_A_BIT]  = sum_a;
      stat_word[MAC_TS_BIT] = mac_q.ts;
      stat_word[MAC_PM_BIT] = mac_q.pm;
      en_word               = '0;
      en_word[N_EV-1:0]     = ev_en_q;
      en_word[SUM_N_BIT]    = grp_n_en_q;
      en_word[SUM_A_BIT]    = grp_a_en_q;
      en_word[MAC_TS_BIT]   = mac_en_q.ts;
      en_word[MAC_PM_BIT]   = mac_en_q.pm;
   end

   always_comb begin
      if (rd_addr == ADDR_W'(STAT_ADDR))    rd_data = stat_word;
      else if (rd_addr == ADDR_W'(EN_ADDR)) rd_data = en_word;
      else                                  rd_data = '0;
   end

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
   parameter int N_NORM = 8,
   parameter int N_ABN  = 8,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [N_NORM-1:0]        norm_evt,
   input logic [N_ABN-1:0]         abn_evt,
   input logic                     mac_ts_lvl,
   input logic                     mac_pm_lvl,
   input logic                     wr_en,
   input logic [ADDR_W-1:0]        wr_addr,
   input logic [DATA_W-1:0]        wr_data,
   input logic [N_NORM+N_ABN-1:0]  ev_q,
   input logic [N_NORM+N_ABN-1:0]  ev_en_q,
   input logic                     sum_n,
   input logic                     sum_a,
   input logic                     grp_n_en_q,
   input logic                     grp_a_en_q,
   input logic [1:0]               mac_q,
   input logic                     irq
);

   localparam int N_EV = N_NORM + N_ABN;

   logic warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) warm <= 1'b0;
      else        warm <= 1'b1;
   end

   // R1 R3
   evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|{abn_evt, norm_evt}) |=>
      ((ev_q & $past({abn_evt, norm_evt})) == $past({abn_evt, norm_evt})));

   // R2
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == '0) |=>
      ((ev_q & $past(wr_data[N_EV-1:0] & ~{abn_evt, norm_evt})) == '0));

   // R7
   mac_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      warm |=> (mac_q == $past({mac_pm_lvl, mac_ts_lvl})));

   // R6
   irq_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      warm |=> (irq == $past((sum_n && grp_n_en_q) || (sum_a && grp_a_en_q))));

   // R5
   abn_sum_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_q[N_EV-1:N_NORM] & ev_en_q[N_EV-1:N_NORM]) == '0) |-> !sum_a);

endmodule

bind irq_status_ctrl irq_status_chk #(
   .N_NORM (N_NORM),
   .N_ABN  (N_ABN),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .norm_evt   (norm_evt),
   .abn_evt    (abn_evt),
   .mac_ts_lvl (mac_ts_lvl),
   .mac_pm_lvl (mac_pm_lvl),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .ev_q       (ev_q),
   .ev_en_q    (ev_en_q),
   .sum_n      (sum_n),
   .sum_a      (sum_a),
   .grp_n_en_q (grp_n_en_q),
   .grp_a_en_q (grp_a_en_q),
   .mac_q      (mac_q),
   .irq        (irq)
);

// File: tb/sim_irq_status_ctrl.sv
`timescale 1ns/100ps
module sim_irq_status_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  norm_evt = '0;
   logic [7:0]  abn_evt = '0;
   logic        mac_ts_lvl = 1'b0, mac_pm_lvl = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq;

   int checks = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;   // 250 MHz

   irq_status_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .norm_evt(norm_evt), .abn_evt(abn_evt),
      .mac_ts_lvl(mac_ts_lvl), .mac_pm_lvl(mac_pm_lvl), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq(irq)
   );

   typedef struct packed {
      logic [7:0]  n;
      logic [7:0]  a;
      logic        ts;
      logic        pm;
      logic [31:0] clr;
      logic [31:0] exp_stat;
      logic        exp_irq;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{8'h40, 8'h00, 1'b0, 1'b0, 32'h0000_0000, 32'h0001_0040, 1'b1}, // R1 rx done
      '{8'h40, 8'h00, 1'b0, 1'b0, 32'h0000_0000, 32'h0001_0040, 1'b1}, // R4 repeat
      '{8'h00, 8'h00, 1'b0, 1'b0, 32'h0000_0040, 32'h0000_0000, 1'b0}, // R2 clear
      '{8'h03, 8'h01, 1'b0, 1'b0, 32'h0000_0000, 32'h0003_0103, 1'b1}, // R1 R5 both groups
      '{8'h01, 8'h00, 1'b0, 1'b0, 32'h0000_0101, 32'h0001_0003, 1'b1}, // R3 event beats clear
      '{8'h00, 8'h00, 1'b0, 1'b0, 32'h0000_0003, 32'h0000_0000, 1'b0}, // R2 R5 all cleared
      '{8'h00, 8'h00, 1'b1, 1'b0, 32'h0000_0000, 32'h0011_0000, 1'b1}, // R7 ts level
      '{8'h00, 8'h00, 1'b1, 1'b0, 32'h0010_0000, 32'h0011_0000, 1'b1}, // R7 not clearable
      '{8'h00, 8'h00, 1'b0, 1'b1, 32'h0000_0000, 32'h0021_0000, 1'b1}, // R7 pm level
      '{8'h00, 8'h80, 1'b0, 1'b0, 32'h0000_0000, 32'h0002_8000, 1'b1}, // R1 abnormal top
      '{8'h00, 8'h00, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_0000, 1'b0}  // R2 R5
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      rd_addr = a;
      #0.5;
      d = rd_data;
   endtask

   // drive one cycle, then release pulses and write strobe
   task automatic cyc(input logic [7:0] n, input logic [7:0] a,
                      input logic we, input logic [1:0] wa, input logic [31:0] wd);
      norm_evt = n; abn_evt = a; wr_en = we; wr_addr = wa; wr_data = wd;
      @(posedge clk); #1;
      norm_evt = '0; abn_evt = '0; wr_en = 1'b0;
   endtask

   task automatic idle();
      @(posedge clk); #1;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      #1;
      // R9 reset state
      rd(2'd0, d); chk("R9 status", d, 32'h0);
      rd(2'd1, d); chk("R9 enable", d, 32'h0);
      chk("R9 irq", {31'b0, irq}, 32'h0);
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      idle();

      // R8 enable mask
      cyc('0, '0, 1'b1, 2'd1, 32'hFFFF_FFFF);
      rd(2'd1, d); chk("R8 enable mask", d, 32'h0033_FFFF);
      rd(2'd3, d); chk("R8 unused addr", d, 32'h0);

      // vector walk
      for (int i = 0; i < NV; i++) begin
         mac_ts_lvl = VEC[i].ts; mac_pm_lvl = VEC[i].pm;
         cyc(VEC[i].n, VEC[i].a, VEC[i].clr != 0, 2'd0, VEC[i].clr);
         idle();
         rd(2'd0, d); chk($sformatf("vec%0d status", i), d, VEC[i].exp_stat);
         chk($sformatf("vec%0d irq R6", i), {31'b0, irq}, {31'b0, VEC[i].exp_irq});
      end

      // R5 masked bit visible, no summary, no irq
      cyc('0, '0, 1'b1, 2'd1, 32'h0033_FFBF);
      cyc(8'h40, '0, 1'b0, 2'd0, 32'h0);
      rd(2'd0, d); chk("R5 masked status", d, 32'h0000_0040);
      idle();
      chk("R5 masked irq", {31'b0, irq}, 32'h0);
      // R8 summary not writable via status write
      cyc('0, '0, 1'b1, 2'd0, 32'h0003_0000);
      rd(2'd0, d); chk("R8 summary write ignored", d, 32'h0000_0040);
      // R6 unmask: summary now, irq one edge later
      cyc('0, '0, 1'b1, 2'd1, 32'h0033_FFFF);
      rd(2'd0, d); chk("R5 summary after unmask", d, 32'h0001_0040);
      chk("R6 irq not yet", {31'b0, irq}, 32'h0);
      idle();
      chk("R6 irq one edge later", {31'b0, irq}, 32'h1);
      // R4 repeated events: irq never drops
      for (int k = 0; k < 3; k++) begin
         cyc(8'h40, '0, 1'b0, 2'd0, 32'h0);
         chk("R4 irq held", {31'b0, irq}, 32'h1);
      end
      rd(2'd0, d); chk("R4 status unchanged", d, 32'h0001_0040);
      // R6 group enable off
      cyc('0, '0, 1'b1, 2'd1, 32'h0032_FFFF);
      idle();
      rd(2'd0, d); chk("R5 summary with group off", d, 32'h0001_0040);
      chk("R6 group gate", {31'b0, irq}, 32'h0);

      // R9 mid-run reset
      #0.5 rst_n = 1'b0;
      #0.5;
      rd(2'd0, d); chk("R9 status after reset", d, 32'h0);
      rd(2'd1, d); chk("R9 enable after reset", d, 32'h0);
      chk("R9 irq after reset", {31'b0, irq}, 32'h0);

      done = 1;
      summary();
      $finish;
   end

endmodule